// File: doc/BRIEF.md
# Crossing History Tapped Capture Register

This block keeps a short history of one data word per crossing tick. On every clock edge a new word is taken in through an input latch, and the word latched on the previous edge moves into the newest stage of a delay line of up to 32 stages. Every older stage moves one place deeper. A static tap-select value picks one stage of this line. The picked stage feeds two separate holding registers: one serves event readout and one serves monitoring.

Each holding register has its own active-low capture enable. It loads the tapped word only on a tick when that enable is low. On every other tick it keeps its contents, so the word stays available until a later capture replaces it. To set the tap, system integration matches it to the fixed delay between a crossing and its accept decision. The captured word then belongs to the crossing that was accepted.

There is no sequencing state. The block is the delay line, a decoded tap selector and two load-enabled registers, and every edge treats them the same way.

Top module: `xing_tap_capture`

## Requirements
- R1: A synchronous active-high reset clears the input latch, every history stage and both holding registers to zero, and capture enables are ignored on a reset tick.
- R2: On each clock edge the input word is latched, the previously latched word enters the newest history stage, and each stage passes its word one stage deeper.
- R3: A capture whose enable is sampled low at edge e with tap value t makes the held word, after edge e, equal to the input word sampled at edge e-2-t. If that word was sampled at or before the last reset edge, the held word is zero.
- R4: The tap select is 5 bits wide and covers stages 0 to 31. Value 0 is the newest stage and value 31 is the oldest.
- R5: The event holding register loads only on an edge where `evt_cap_n` is low. Otherwise `evt_word` keeps its value.
- R6: The monitor holding register loads only on an edge where `mon_cap_n` is low. Otherwise `mon_word` keeps its value, whatever `evt_cap_n` does.
- R7: When both capture enables are low on the same edge, both holding registers load the identical tapped word.
- R8: A new capture overwrites the held word, including captures on back-to-back ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing tick clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 16 | Data word for the current crossing |
| tap_sel | input | 5 | Static history stage select, 0 = newest |
| evt_cap_n | input | 1 | Event capture enable, active low, one tick |
| mon_cap_n | input | 1 | Monitor capture enable, active low, one tick |
| evt_word | output | 16 | Event holding register contents |
| mon_word | output | 16 | Monitor holding register contents |

## Verification
The bench targets the two-edge input offset. A design that drops the input latch, or adds one register too many, returns the neighbouring crossing's word at every tap. The bench also captures at tap 31 and just after reset, where a design with the wrong tap order or an incomplete reset clear returns stale or inverted history instead of zero or the oldest word. Back-to-back and simultaneous captures on both registers expose enables that cross-couple, and they expose a holding register that drifts with the line when its enable is high.

// File: rtl/xing_tap_capture_pkg.sv
package xing_tap_capture_pkg;

    // Holding channels fed from the shared tap.
    typedef enum logic [0:0] {
        CH_EVENT   = 1'b0,
        CH_MONITOR = 1'b1
    } hold_chan_e;

    localparam int HOLD_CHANNELS = 2;

endpackage

// File: rtl/xing_history_line.sv
module xing_history_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DATA_W-1:0]              din,
    output logic [DEPTH-1:0][DATA_W-1:0]   stages_o
);

    // Input latch: holds the current crossing's word.
    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= din;
    end

    // Stage 0 takes the previous crossing from the latch on the same edge.
    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= in_q;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_q[i-1];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign stages_o[i] = stage_q[i];
    end

endmodule

// File: rtl/xing_tap_mux.sv
module xing_tap_mux #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int SEL_W  = 5
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] stages_i,
    input  logic [SEL_W-1:0]             sel_i,
    output logic [DATA_W-1:0]            word_o
);

    // Decoded AND-OR selection: one compare per stage, shallow OR tree.
    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign hit[i] = (sel_i == SEL_W'(i));
    end

    always_comb begin
        word_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            word_o = word_o | (stages_i[i] & {DATA_W{hit[i]}});
        end
    end

endmodule

// File: rtl/xing_hold_reg.sv
module xing_hold_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_n,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst)         q_o <= '0;
        else if (!cap_n) q_o <= d_i;
    end

endmodule

// File: rtl/xing_tap_capture.sv
module xing_tap_capture
    import xing_tap_capture_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int SEL_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [SEL_W-1:0]  tap_sel,
    input  logic              evt_cap_n,
    input  logic              mon_cap_n,
    output logic [DATA_W-1:0] evt_word,
    output logic [DATA_W-1:0] mon_word
);

    logic [DEPTH-1:0][DATA_W-1:0] stages;
    logic [DATA_W-1:0]            tapped;
    logic [HOLD_CHANNELS-1:0]     cap_n_v;
    logic [DATA_W-1:0]            held [HOLD_CHANNELS];

    xing_history_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_line (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .stages_o (stages)
    );

    xing_tap_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_tap (
        .stages_i (stages),
        .sel_i    (tap_sel),
        .word_o   (tapped)
    );

    assign cap_n_v[CH_EVENT]   = evt_cap_n;
    assign cap_n_v[CH_MONITOR] = mon_cap_n;

    for (genvar k = 0; k < HOLD_CHANNELS; k++) begin : g_hold
        xing_hold_reg #(.DATA_W(DATA_W)) u_hold (
            .clk   (clk),
            .rst   (rst),
            .cap_n (cap_n_v[k]),
            .d_i   (tapped),
            .q_o   (held[k])
        );
    end

    assign evt_word = held[CH_EVENT];
    assign mon_word = held[CH_MONITOR];

endmodule

// File: rtl/xing_tap_capture_chk.sv
module xing_tap_capture_chk #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic [SEL_W-1:0]  tap_sel,
    input logic              evt_cap_n,
    input logic              mon_cap_n,
    input logic [DATA_W-1:0] evt_word,
    input logic [DATA_W-1:0] mon_word
);

    // Edges with reset low since the last reset edge, saturating.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (evt_word == '0 && mon_word == '0));

    p_evt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        evt_cap_n |=> $stable(evt_word));

    p_mon_hold_r6: assert property (@(posedge clk) disable iff (rst)
        mon_cap_n |=> $stable(mon_word));

    p_both_equal_r7: assert property (@(posedge clk) disable iff (rst)
        (!evt_cap_n && !mon_cap_n) |=> (evt_word == mon_word));

    p_evt_tap0_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && tap_sel == '0 && !evt_cap_n)
            |=> (evt_word == $past(din, 3)));

    p_mon_tap0_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && tap_sel == '0 && !mon_cap_n)
            |=> (mon_word == $past(din, 3)));

endmodule

bind xing_tap_capture xing_tap_capture_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .tap_sel   (tap_sel),
    .evt_cap_n (evt_cap_n),
    .mon_cap_n (mon_cap_n),
    .evt_word  (evt_word),
    .mon_word  (mon_word)
);

// File: tb/xing_tap_capture_tb_top.sv
module xing_tap_capture_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [4:0]   tap_sel = '0;
    logic         evt_cap_n = 1'b1;
    logic         mon_cap_n = 1'b1;
    logic [W-1:0] evt_word;
    logic [W-1:0] mon_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xing_tap_capture dut_i (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .tap_sel   (tap_sel),
        .evt_cap_n (evt_cap_n),
        .mon_cap_n (mon_cap_n),
        .evt_word  (evt_word),
        .mon_word  (mon_word)
    );

    // Edge counter: edge n is the n-th rising edge.
    int edge_n = 0;
    always @(posedge clk) edge_n <= edge_n + 1;

    // Bench model state, derived from the requirements.
    logic [W-1:0] sent [0:4095];
    int           first_valid = 0;
    logic [W-1:0] model_evt = '0;
    logic [W-1:0] model_mon = '0;

    // Scoreboard queues.
    int           q_edge [$];
    logic [W-1:0] q_evt  [$];
    logic [W-1:0] q_mon  [$];
    string        q_req  [$];

    function automatic logic [W-1:0] pat(input int e);
        pat = W'(e * 16'h9E37 + 16'h1234);
    endfunction

    // Driver: one tick of stimulus, pushes the expected held words.
    task automatic step(input bit do_rst, input bit ce, input bit cm,
                        input int tap, input string req);
        int e;
        int idx;
        logic [W-1:0] v;
        @(negedge clk);
        e = edge_n + 1;
        din       = pat(e);
        sent[e]   = pat(e);
        rst       = do_rst;
        evt_cap_n = !ce;
        mon_cap_n = !cm;
        tap_sel   = 5'(tap);
        if (do_rst) begin
            model_evt   = '0;
            model_mon   = '0;
            first_valid = e + 1;
        end else begin
            idx = e - 2 - tap;
            v = (idx >= first_valid) ? sent[idx] : '0;
            if (ce) model_evt = v;
            if (cm) model_mon = v;
        end
        q_edge.push_back(e);
        q_evt.push_back(model_evt);
        q_mon.push_back(model_mon);
        q_req.push_back(req);
    endtask

    // Monitor: compares after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q_edge.size() > 0 && q_edge[0] <= edge_n) begin
                int   ed;
                logic [W-1:0] xe;
                logic [W-1:0] xm;
                string rq;
                ed = q_edge.pop_front();
                xe = q_evt.pop_front();
                xm = q_mon.pop_front();
                rq = q_req.pop_front();
                checks++;
                if (evt_word !== xe) begin
                    errors++;
                    $display("FAIL %s edge %0d evt_word actual %h expected %h",
                             rq, ed, evt_word, xe);
                end
                checks++;
                if (mon_word !== xm) begin
                    errors++;
                    $display("FAIL %s edge %0d mon_word actual %h expected %h",
                             rq, ed, mon_word, xm);
                end
            end
        end
    end

    initial begin
        // R1: reset clears everything; enables low during reset are ignored.
        step(1, 0, 0, 0, "R1");
        step(1, 1, 1, 0, "R1");
        step(1, 0, 0, 31, "R1");
        // R3: capture straight after reset reads the cleared line (zero).
        step(0, 1, 0, 0, "R3");
        step(0, 0, 1, 31, "R3");
        // R5/R6: long idle, both registers hold.
        for (int i = 0; i < 40; i++) step(0, 0, 0, 3, "R5");
        // R3/R4: tap 0 newest, event only; monitor keeps value (R6).
        step(0, 1, 0, 0, "R4");
        step(0, 0, 0, 0, "R6");
        // R6: monitor only at tap 5; event keeps value (R5).
        step(0, 0, 1, 5, "R6");
        step(0, 0, 0, 5, "R5");
        // R4/R7: tap 31 oldest, both at once.
        step(0, 1, 1, 31, "R7");
        step(0, 0, 0, 31, "R4");
        // R8: back-to-back overwrite.
        step(0, 1, 0, 2, "R8");
        step(0, 1, 0, 2, "R8");
        step(0, 1, 1, 9, "R8");
        step(0, 0, 1, 9, "R8");
        // R2/R3: sweep of taps and enable patterns.
        for (int i = 0; i < 220; i++)
            step(0, (i % 7) == 0, (i % 11) == 3, (i * 13) % 32, "R3");
        for (int t = 0; t < 32; t++) step(0, 1, (t % 2) == 1, t, "R2");
        // R1: mid-run reset, then the oldest tap reads zero until refilled.
        step(1, 0, 0, 31, "R1");
        for (int i = 0; i < 36; i++) step(0, 1, 1, 31, "R1");
        step(0, 0, 0, 0, "R5");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule